// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is an SPI slave that behaves like a small byte-wide nonvolatile memory. A register array stands in for the storage cells, so the block can be used in simulation models, prototypes or emulation platforms wherever a host expects a serial EEPROM on its SPI bus. The SPI pins are oversampled on the system clock through a synchronizer. The memory is reached only through the SPI frame. SPI has no back-pressure, so there is no valid/ready stream at the boundary. The host paces every byte with SCK, and the slave must keep up with each edge. To make that possible, SCK must stay at least four system clocks in each phase.

The host lowers chip select, shifts an instruction byte and any address and data bytes in on SI, and reads returned bytes on SO. Writes first land in an eight-byte page buffer. The array is updated only when chip select rises on a byte boundary. After that, a busy counter stands in for the self-timed programming time. A write-enable latch, a two-bit block-protect field, a write-protect pin and a HOLD pin guard the array or pause the transfer.

Top module: `eep_spi_slave`

## Requirements
- R1: After reset, so_oe is low whenever chip select is high, and the status byte reads 0x00.
- R2: Instruction 0x05 returns the status byte {4'b0000, protect[1:0], latch, busy}: bit 0 is busy, bit 1 is the write-enable latch, and bits 3:2 are the protect field. The status byte repeats for every further byte clocked in the same frame.
- R3: Instruction 0x06 sets the write-enable latch and 0x04 clears it. A data write (0x02) or a status write (0x01) issued while the latch is clear leaves the array and the status unchanged.
- R4: Instruction 0x02 is followed by an address byte and data bytes. The array changes only when chip select rises after a whole number of bytes. A frame that ends mid-byte changes nothing and leaves the latch set.
- R5: Data bytes fill the page addressed by the upper address bits, starting at the offset given by the low three bits. The offset wraps within the eight-byte page, so only the last eight bytes of a longer burst are kept.
- R6: A status write stores data bits 3:2 in the protect field. The protect field selects which writes are ignored: 00 protects nothing, 01 the top quarter, 10 the top half, 11 the whole array. While wp_n is low, a status write is ignored.
- R7: A committed write or status write holds busy for WR_CYCLES clocks and clears the latch when busy ends. While busy, every instruction except 0x05 is ignored.
- R8: Instruction 0x03 streams bytes from the start address, incrementing and wrapping from the last address to 0. For 512 words, address bit 8 travels in bit 3 of the READ and WRITE instruction bytes.
- R9: With hold_n low and SCK low, so_oe drops and SCK edges are ignored. When hold_n is released with SCK low, the transfer resumes at the bit where it stopped.
- R10: SPI modes 0 and 3 both work: SI is sampled on rising SCK, SO changes after falling SCK, and SCK may idle low or high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for so (high-impedance when low) |

## Verification
The page write is tried with a short burst inside a page, with a ten-byte burst that starts near the end of a page, and with a frame cut three bits into a byte. These patterns separate plain incrementing from in-page wraparound with last-eight retention and from boundary-gated commits. Reads start near the top of the array and run in both SPI modes, which exposes a missing address carry or a mode-dependent first bit. Protect levels are stepped through addresses just outside and just inside each fraction. Busy-time instructions and a mid-byte HOLD with SCK toggled while paused show whether ignored stimulus leaks into the state.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  // bit 3 of READ/WRITE carries the ninth address bit
  localparam logic [7:0] OP_AMASK = 8'hF7;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRR, ST_SRW, ST_SKIP
  } eep_state_t;

  // top: two most significant address bits
  function automatic logic bp_covers(input logic [1:0] bp, input logic [1:0] top);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top == 2'b11;
      2'b10:   return top[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/eep_spi_front.sv
module eep_spi_front #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic sel,
  output logic held,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic si_s,
  output logic wp_ok
);
  localparam int NIN = 5;
  // order {sck, cs_n, si, hold_n, wp_n}
  localparam logic [NIN-1:0] RSTV = 5'b01011;

  logic [NIN-1:0] raw, syn;
  assign raw = {sck, cs_n, si, hold_n, wp_n};

  for (genvar g = 0; g < NIN; g++) begin : g_sync
    logic [SYNC-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {SYNC{RSTV[g]}};
      else        chain <= {chain[SYNC-2:0], raw[g]};
    end
    assign syn[g] = chain[SYNC-1];
  end

  logic sck_s, cs_s, hold_s;
  assign sck_s  = syn[4];
  assign cs_s   = syn[3];
  assign si_s   = syn[2];
  assign hold_s = syn[1];
  assign wp_ok  = syn[0];

  logic sck_q, cs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      held  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      if (cs_s)        held <= 1'b0;
      else if (!sck_s) held <= !hold_s;
    end
  end

  assign sel      = !cs_s;
  assign sck_rise = sel && !held && sck_s && !sck_q;
  assign sck_fall = sel && !held && !sck_s && sck_q;
  assign cs_rise  = cs_s && !cs_q;
  assign cs_fall  = !cs_s && cs_q;

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int unsigned PAGE = 8,
  parameter int unsigned DW   = 8,
  localparam int unsigned PW  = $clog2(PAGE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [PW-1:0]           load_off,
  input  logic                    push,
  input  logic [DW-1:0]           din,
  output logic [PAGE-1:0][DW-1:0] data,
  output logic [PAGE-1:0]         mask
);
  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      mask <= '0;
      data <= '0;
    end else if (load) begin
      ptr  <= load_off;
      mask <= '0;
    end else if (push) begin
      data[ptr] <= din;
      mask[ptr] <= 1'b1;
      ptr       <= ptr + 1'b1;
    end
  end

  p_fill_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push && !load |=> $countones(mask) >= $countones($past(mask)) && mask != '0);

endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int unsigned CYCLES = 500000,
  localparam int unsigned CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = cnt != '0;
  assign done = cnt == CW'(1);

  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave
  import eep_pkg::*;
#(
  parameter int unsigned DEPTH     = 512,
  parameter int unsigned PAGE      = 8,
  parameter int unsigned WR_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = $clog2(PAGE);

  logic sel, held, sck_rise, sck_fall, cs_rise, cs_fall, si_s, wp_ok;

  eep_spi_front #(.SYNC(2)) u_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .sel(sel), .held(held),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .si_s(si_s), .wp_ok(wp_ok)
  );

  eep_state_t     st;
  logic [2:0]     bitcnt;
  logic [7:0]     sh_in, out_sh;
  logic           so_q, a8_q, is_wr, wel, sr_got;
  logic [1:0]     bp, bp_new;
  logic [AW-1:0]  addr_q;

  logic [7:0] byte_in;
  logic       byte_done;
  assign byte_in   = {sh_in[6:0], si_s};
  assign byte_done = sck_rise && (bitcnt == 3'd7);

  logic [8:0]    full_addr;
  logic [AW-1:0] addr_load, addr_nxt;
  assign full_addr = {a8_q, byte_in};
  assign addr_load = full_addr[AW-1:0];
  assign addr_nxt  = addr_q + 1'b1;

  logic busy, wr_done;
  logic wr_commit, sr_commit;

  eep_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_commit || sr_commit),
    .busy(busy), .done(wr_done)
  );

  logic [PAGE-1:0][7:0] pg_data;
  logic [PAGE-1:0]      pg_mask;
  logic                 pg_load, pg_push;
  assign pg_load = byte_done && (st == ST_ADDR) && is_wr;
  assign pg_push = byte_done && (st == ST_WDATA);

  eep_page_buf #(.PAGE(PAGE), .DW(8)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .load(pg_load), .load_off(byte_in[PW-1:0]),
    .push(pg_push), .din(byte_in), .data(pg_data), .mask(pg_mask)
  );

  logic [7:0] mem [DEPTH];
  logic [7:0] status;
  logic       prot;
  assign status = {4'b0000, bp, wel, busy};
  assign prot   = bp_covers(bp, addr_q[AW-1:AW-2]);

  assign wr_commit = cs_rise && (st == ST_WDATA) && (bitcnt == 3'd0) &&
                     (pg_mask != '0) && wel && !prot;
  assign sr_commit = cs_rise && (st == ST_SRW) && (bitcnt == 3'd0) &&
                     sr_got && wel && wp_ok;

  // array: whole page committed in one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (wr_commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pg_mask[i]) mem[{addr_q[AW-1:PW], PW'(i)}] <= pg_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_SKIP;
      bitcnt <= '0;
      sh_in  <= '0;
      out_sh <= '0;
      so_q   <= 1'b0;
      a8_q   <= 1'b0;
      is_wr  <= 1'b0;
      wel    <= 1'b0;
      sr_got <= 1'b0;
      bp     <= '0;
      bp_new <= '0;
      addr_q <= '0;
    end else begin
      if (wr_done)   wel <= 1'b0;
      if (sr_commit) bp  <= bp_new;
      if (cs_fall) begin
        st     <= ST_CMD;
        bitcnt <= '0;
        sr_got <= 1'b0;
      end else if (cs_rise) begin
        st <= ST_SKIP;
      end else begin
        if (sck_rise) begin
          sh_in  <= byte_in;
          bitcnt <= bitcnt + 1'b1;
        end
        if (sck_fall && (st == ST_RDATA || st == ST_SRR)) begin
          so_q   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
        if (byte_done) begin
          case (st)
            ST_CMD: begin
              if (busy && byte_in != OP_RDSR) st <= ST_SKIP;
              else if (byte_in == OP_WREN) begin wel <= 1'b1; st <= ST_SKIP; end
              else if (byte_in == OP_WRDI) begin wel <= 1'b0; st <= ST_SKIP; end
              else if (byte_in == OP_RDSR) begin out_sh <= status; st <= ST_SRR; end
              else if (byte_in == OP_WRSR) st <= ST_SRW;
              else if ((byte_in & OP_AMASK) == OP_READ) begin
                a8_q <= byte_in[3]; is_wr <= 1'b0; st <= ST_ADDR;
              end else if ((byte_in & OP_AMASK) == OP_WRITE) begin
                a8_q <= byte_in[3]; is_wr <= 1'b1; st <= ST_ADDR;
              end else st <= ST_SKIP;
            end
            ST_ADDR: begin
              addr_q <= addr_load;
              if (is_wr) st <= ST_WDATA;
              else begin
                out_sh <= mem[addr_load];
                st     <= ST_RDATA;
              end
            end
            ST_RDATA: begin
              addr_q <= addr_nxt;
              out_sh <= mem[addr_nxt];
            end
            ST_SRR: out_sh <= status;
            ST_SRW: begin
              bp_new <= byte_in[3:2];
              sr_got <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = sel && !held;

  p_hold_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(bitcnt) && $stable(sh_in));

  p_bp_guarded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $past(wel) && $past(wp_ok));

  p_wel_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  p_commit_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bitcnt) == 3'd0 && $past(cs_rise));

endmodule

// File: tb/eep_spi_slave_bench.sv
module eep_spi_slave_bench;
  localparam int HP  = 8;
  localparam int WRC = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;

  always #5 clk = ~clk;

  eep_spi_slave #(.DEPTH(512), .PAGE(8), .WR_CYCLES(WRC)) u_eep_spi_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  int tests = 0, fails = 0;
  bit mode3 = 1'b0;
  logic [7:0] mem_m [512];

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  event rx_ev;
  logic [7:0] rx_last;

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: got %02h expected none", rx_last);
    end else begin
      exp_t e;
      e = exp_q.pop_front();
      check8(e.tag, rx_last, e.v);
    end
  end

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; si = tx[7-i]; hw(HP);
      rx = {rx[6:0], so};
      sck = 1'b1; hw(HP);
    end
  endtask

  task automatic xfer(input logic [7:0] tx);
    logic [7:0] d;
    xbits(tx, 8, d);
  endtask

  task automatic xchk(input logic [7:0] tx, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    exp_q.push_back('{v: exp, tag: tag});
    xbits(tx, 8, r);
    rx_last = r;
    ->rx_ev;
    hw(1);
  endtask

  task automatic begin_x();
    sck = mode3; hw(HP);
    cs_n = 1'b0; hw(HP);
  endtask

  task automatic end_x();
    if (!mode3) sck = 1'b0;
    hw(HP);
    cs_n = 1'b1; hw(2*HP);
  endtask

  task automatic cmd(input logic [7:0] op);
    begin_x(); xfer(op); end_x();
  endtask

  task automatic rdsr(input logic [7:0] exp, input string tag);
    begin_x(); xfer(8'h05); xchk(8'h00, exp, tag); end_x();
  endtask

  task automatic wrsr(input logic [7:0] v);
    begin_x(); xfer(8'h01); xfer(v); end_x();
  endtask

  // commit: whether the requirements say the array changes
  task automatic wr(input logic [8:0] a, input int n, input logic [7:0] base,
                    input int partial, input bit commit);
    logic [7:0] d;
    begin_x();
    xfer(8'h02 | {4'b0, a[8], 3'b0});
    xfer(a[7:0]);
    for (int k = 0; k < n; k++) xfer(8'(base + k * 7));
    if (partial > 0) xbits(8'hA5, partial, d);
    end_x();
    if (commit)
      for (int k = 0; k < n; k++)
        mem_m[{a[8:3], 3'(a[2:0] + k)}] = 8'(base + k * 7);
  endtask

  task automatic rd(input logic [8:0] a, input int n, input string tag);
    begin_x();
    xfer(8'h03 | {4'b0, a[8], 3'b0});
    xfer(a[7:0]);
    for (int k = 0; k < n; k++) xchk(8'h00, mem_m[9'(a + k)], tag);
    end_x();
  endtask

  task automatic wait_wr();
    hw(WRC + 50);
  endtask

  initial begin
    logic [7:0] r1, r2;
    for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
    hw(10); rst_n = 1'b1; hw(10);

    check8("R1 so_oe idle", {7'b0, so_oe}, 8'h00);
    rdsr(8'h00, "R1 status after reset");

    // latch gating
    wr(9'h020, 2, 8'h55, 0, 1'b0);
    wait_wr();
    rd(9'h020, 1, "R3 write without latch");
    rdsr(8'h00, "R3 no busy without latch");
    cmd(8'h06); rdsr(8'h02, "R3 latch set");
    cmd(8'h04); rdsr(8'h00, "R3 latch cleared");

    // repeated status
    cmd(8'h06);
    begin_x(); xfer(8'h05);
    xchk(8'h00, 8'h02, "R2 status byte 1");
    xchk(8'h00, 8'h02, "R2 status byte 2");
    end_x();

    // committed write and busy
    wr(9'h010, 3, 8'h11, 0, 1'b1);
    rdsr(8'h03, "R7 busy and latch");
    cmd(8'h04);
    rdsr(8'h03, "R7 WRDI ignored while busy");
    wait_wr();
    rdsr(8'h00, "R7 latch cleared at end");
    rd(9'h010, 3, "R4 committed bytes");

    // mid-byte abort
    cmd(8'h06);
    wr(9'h030, 2, 8'h66, 3, 1'b0);
    rdsr(8'h02, "R4 abort keeps latch, no busy");
    rd(9'h030, 2, "R4 aborted write");
    cmd(8'h04);

    // page wrap and read wrap
    cmd(8'h06);
    wr(9'h1FC, 10, 8'h40, 0, 1'b1);
    wait_wr();
    rd(9'h1F8, 8, "R5 page wrap last eight");
    rd(9'h1FF, 2, "R8 read wraps to 0");

    // mode 3
    mode3 = 1'b1;
    rd(9'h010, 3, "R10 mode 3 read");
    rdsr(8'h00, "R10 mode 3 status");
    mode3 = 1'b0;

    // block protection
    cmd(8'h06); wrsr(8'h04); wait_wr();
    rdsr(8'h04, "R6 protect quarter");
    cmd(8'h06);
    wr(9'h180, 1, 8'h21, 0, 1'b0);
    rdsr(8'h06, "R6 protected write no busy");
    wr(9'h178, 1, 8'h22, 0, 1'b1);
    wait_wr();
    rd(9'h180, 1, "R6 quarter protected");
    rd(9'h178, 1, "R6 below quarter written");
    cmd(8'h06); wrsr(8'h08); wait_wr();
    cmd(8'h06);
    wr(9'h100, 1, 8'h23, 0, 1'b0);
    rdsr(8'h0A, "R6 half protected no busy");
    rd(9'h100, 1, "R6 half protected");
    wrsr(8'h0C); wait_wr();
    cmd(8'h06);
    wr(9'h000, 1, 8'h24, 0, 1'b0);
    rdsr(8'h0E, "R6 all protected no busy");
    rd(9'h000, 1, "R6 all protected");

    // write-protect pin
    wp_n = 1'b0; hw(10);
    wrsr(8'h00); hw(50);
    rdsr(8'h0E, "R6 wp_n blocks status write");
    wp_n = 1'b1; hw(10);
    wrsr(8'h00); wait_wr();
    rdsr(8'h00, "R6 status write after wp_n released");

    // HOLD in the middle of a data byte
    begin_x();
    xfer(8'h03); xfer(8'h10);
    xbits(8'h00, 3, r1);
    sck = 1'b0; hw(HP);
    hold_n = 1'b0; hw(HP);
    check8("R9 so_oe low while held", {7'b0, so_oe}, 8'h00);
    sck = 1'b1; si = 1'b1; hw(HP);
    sck = 1'b0; hw(HP);
    sck = 1'b1; hw(HP);
    sck = 1'b0; hw(HP);
    hold_n = 1'b1; hw(HP);
    check8("R9 so_oe back after release", {7'b0, so_oe}, 8'h01);
    xbits(8'h00, 5, r2);
    check8("R9 byte across hold", {r1[2:0], r2[4:0]}, mem_m[9'h010]);
    xchk(8'h00, mem_m[9'h011], "R9 next byte after hold");
    end_x();

    hw(20);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule